// File: doc/BRIEF.md
# Memory-Mapped Bus Decoder with ROM, I/O and RAM Regions

This block is the memory side of a small processor system with an 8-bit data bus and a 16-bit address bus. Every bus address is decoded into one of three regions: a 12 KB read-only region at the bottom of the map, a 4 KB window of byte-wide I/O registers above it, and a 16 KB read/write region above that. The upper 32 KB is left unmapped. For each region there is an active-low select output that depends only on the address. The block also contains behavioural storage for all three regions and returns read data through one registered multiplexer.

The processor presents an address with a read strobe or a write strobe for one clock. Read data and the decode-error flag are registered, so they appear one cycle after the strobe and hold until the next access. The read-only contents are not stored in a table. They are computed from the offset, which lets the bench predict every byte. The read/write region is backed by a parameter-sized store that repeats throughout the 16 KB window.

Top module: `sysmem_top`

## Requirements
- R1: Select outputs are active-low and decode from the address alone. `rom_sel_n` is low for 0x0000–0x2FFF, `io_sel_n` is low for 0x3000–0x3FFF and `ram_sel_n` is low for 0x4000–0x7FFF. For every address below 0x8000 exactly one select is low.
- R2: For addresses 0x8000–0xFFFF all three selects are high.
- R3: When `rd_en` is high at a rising edge, `rdata` takes the addressed byte at that edge. When no read occurs at an edge, `rdata` keeps its value.
- R4: A read in the ROM region returns `addr[7:0] ^ {2'b00, addr[13:8]} ^ 8'h5A`.
- R5: A write into the ROM region changes nothing. A later read of the same address still returns the R4 value.
- R6: A read in the RAM region returns the last byte written there. The backing store holds 2**RAM_AW bytes (1024 by default) and is indexed by `addr[RAM_AW-1:0]`, so the store repeats through the region.
- R7: The I/O window holds 16 byte registers selected by `addr[3:0]`. Any address in 0x3000–0x3FFF with the same low nibble reaches the same register.
- R8: A read at 0x8000 or above returns 0xFF and sets `dec_err` high in the following cycle. A write there changes no storage and also sets `dec_err` high in the following cycle.
- R9: After an access to a mapped address, or after a cycle with no strobe, `dec_err` is low.
- R10: Synchronous reset clears all I/O registers, `rdata` and `dec_err` to zero. RAM contents are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rdata | output | 8 | Registered read data |
| dec_err | output | 1 | Registered unmapped-access flag |
| rom_sel_n | output | 1 | Active-low ROM region select |
| io_sel_n | output | 1 | Active-low I/O region select |
| ram_sel_n | output | 1 | Active-low RAM region select |

## Verification
A wrong region boundary shows up right away on the select outputs. It also shows up one cycle later as a byte from the wrong store, for example a ROM pattern where a written RAM value was expected. A write enable that leaks into the wrong store shows up only on a later read. For that reason the bench reads back every aliased and ignored address after the write that could have disturbed it. A stale error flag or stale read register shows up in the cycle after the next access or idle cycle.

// File: rtl/sysmem_pkg.sv
package sysmem_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ROM_LAST = 16'h2FFF;
    localparam logic [ADDR_W-1:0] IO_LAST  = 16'h3FFF;
    localparam logic [ADDR_W-1:0] RAM_LAST = 16'h7FFF;

    localparam logic [DATA_W-1:0] UNMAPPED_BYTE = 8'hFF;
    localparam logic [DATA_W-1:0] ROM_SEED      = 8'h5A;

    typedef enum logic [1:0] {
        RGN_ROM  = 2'd0,
        RGN_IO   = 2'd1,
        RGN_RAM  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } bus_state_t;

    function automatic logic [DATA_W-1:0] rom_byte(input logic [13:0] off);
        return off[7:0] ^ {2'b00, off[13:8]} ^ ROM_SEED;
    endfunction
endpackage

// File: rtl/sysmem_decode.sv
module sysmem_decode
    import sysmem_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              rom_sel_n,
    output logic              io_sel_n,
    output logic              ram_sel_n
);
    always_comb begin
        if (addr <= ROM_LAST)      region = RGN_ROM;
        else if (addr <= IO_LAST)  region = RGN_IO;
        else if (addr <= RAM_LAST) region = RGN_RAM;
        else                       region = RGN_NONE;
        rom_sel_n = (region != RGN_ROM);
        io_sel_n  = (region != RGN_IO);
        ram_sel_n = (region != RGN_RAM);
    end
endmodule

// File: rtl/sysmem_io_bank.sv
module sysmem_io_bank
    import sysmem_pkg::*;
#(
    parameter int IO_REGS = 16,
    localparam int IO_AW  = $clog2(IO_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IO_AW-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs_d [IO_REGS];
    logic [DATA_W-1:0] regs_q [IO_REGS];

    always_comb begin
        for (int i = 0; i < IO_REGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (rst) begin
            for (int i = 0; i < IO_REGS; i++) begin
                regs_d[i] = '0;
            end
        end else if (we) begin
            regs_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < IO_REGS; i++) begin
            regs_q[i] <= regs_d[i];
        end
    end

    assign rdata = regs_q[idx];

    // R10: one cycle after reset the addressed register reads zero
    assert_io_reset_R10: assert property (@(posedge clk)
        $past(rst) && !rst |-> rdata == '0);
endmodule

// File: rtl/sysmem_ram.sv
module sysmem_ram
    import sysmem_pkg::*;
#(
    parameter int RAM_AW = 10,
    localparam int DEPTH = 1 << RAM_AW
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[idx] <= wdata;
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/sysmem_top.sv
module sysmem_top
    import sysmem_pkg::*;
#(
    parameter int RAM_AW  = 10,
    parameter int IO_REGS = 16,
    localparam int IO_AW  = $clog2(IO_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic              dec_err,
    output logic              rom_sel_n,
    output logic              io_sel_n,
    output logic              ram_sel_n
);
    region_e           region;
    logic [DATA_W-1:0] io_rd, ram_rd, mux_rd;
    logic              io_we, ram_we;
    bus_state_t        st_d, st_q;

    sysmem_decode u_dec (
        .addr      (addr),
        .region    (region),
        .rom_sel_n (rom_sel_n),
        .io_sel_n  (io_sel_n),
        .ram_sel_n (ram_sel_n)
    );

    assign io_we  = wr_en && !io_sel_n;
    assign ram_we = wr_en && !ram_sel_n;

    sysmem_io_bank #(.IO_REGS(IO_REGS)) u_io (
        .clk   (clk),
        .rst   (rst),
        .we    (io_we),
        .idx   (addr[IO_AW-1:0]),
        .wdata (wdata),
        .rdata (io_rd)
    );

    sysmem_ram #(.RAM_AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (addr[RAM_AW-1:0]),
        .wdata (wdata),
        .rdata (ram_rd)
    );

    always_comb begin
        unique case (region)
            RGN_ROM: mux_rd = rom_byte(addr[13:0]);
            RGN_IO:  mux_rd = io_rd;
            RGN_RAM: mux_rd = ram_rd;
            default: mux_rd = UNMAPPED_BYTE;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            if (rd_en) st_d.rdata = mux_rd;
            st_d.err = (rd_en || wr_en) && (region == RGN_NONE);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata   = st_q.rdata;
    assign dec_err = st_q.err;

    // R1: below the unused half exactly one select is low
    assert_one_select_R1: assert property (@(posedge clk) disable iff (rst)
        !addr[ADDR_W-1] |-> $countones({rom_sel_n, io_sel_n, ram_sel_n}) == 2);

    // R2: no select in the unused half
    assert_no_select_R2: assert property (@(posedge clk) disable iff (rst)
        addr[ADDR_W-1] |-> (rom_sel_n && io_sel_n && ram_sel_n));

    // R3: read data holds without a read strobe
    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R8: unmapped read gives 0xFF and flags the error next cycle
    assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (rst)
        rd_en && rom_sel_n && io_sel_n && ram_sel_n |=> dec_err && rdata == UNMAPPED_BYTE);

    // R9: error flag stays low after idle cycles
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en && !wr_en |=> !dec_err);
endmodule

// File: tb/tb_sysmem_top.sv
module tb_sysmem_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        rd_en, wr_en;
    logic [7:0]  rdata;
    logic        dec_err, rom_sel_n, io_sel_n, ram_sel_n;

    int total = 0;
    int bad   = 0;

    sysmem_top dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .rdata(rdata), .dec_err(dec_err),
        .rom_sel_n(rom_sel_n), .io_sel_n(io_sel_n), .ram_sel_n(ram_sel_n)
    );

    always #2 clk = ~clk;

    // vector: {is_write, exp_err, addr, wdata, exp_rdata}
    localparam int NV = 17;
    localparam logic [33:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h4000, 8'h11, 8'h00},  // R6 write
        {1'b0, 1'b0, 16'h4000, 8'h00, 8'h11},  // R6 read back
        {1'b1, 1'b0, 16'h7FFF, 8'h22, 8'h00},  // R6 top of region
        {1'b0, 1'b0, 16'h7FFF, 8'h00, 8'h22},  // R6
        {1'b0, 1'b0, 16'h43FF, 8'h00, 8'h22},  // R6 store repeats
        {1'b1, 1'b0, 16'h3005, 8'hA1, 8'h00},  // R7 write
        {1'b0, 1'b0, 16'h3F35, 8'h00, 8'hA1},  // R7 alias
        {1'b0, 1'b0, 16'h3006, 8'h00, 8'h00},  // R7 untouched register
        {1'b1, 1'b0, 16'h0010, 8'h77, 8'h00},  // R5 ROM write
        {1'b0, 1'b0, 16'h0010, 8'h00, 8'h4A},  // R5 ROM unchanged
        {1'b0, 1'b0, 16'h2FFF, 8'h00, 8'h8A},  // R4 last ROM byte
        {1'b0, 1'b0, 16'h1234, 8'h00, 8'h7C},  // R4
        {1'b1, 1'b1, 16'h8000, 8'h55, 8'h00},  // R8 unmapped write
        {1'b0, 1'b1, 16'h8000, 8'h00, 8'hFF},  // R8 unmapped read
        {1'b0, 1'b1, 16'hFFFF, 8'h00, 8'hFF},  // R8
        {1'b0, 1'b0, 16'h4000, 8'h00, 8'h11},  // R8 write ignored, R9 flag low
        {1'b0, 1'b0, 16'h3FF5, 8'h00, 8'hA1}   // R7 alias at window top
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic r, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = w; rd_en = r;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic sel_check(input logic [15:0] a, input logic [2:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(a[15] ? "R2 selects" : "R1 selects", {29'd0, rom_sel_n, io_sel_n, ram_sel_n}, {29'd0, exp});
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = '0; wdata = '0; rd_en = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 rdata reset", {24'd0, rdata}, 32'd0);
        check("R10 err reset", {31'd0, dec_err}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][33], !VEC[i][33], VEC[i][31:16], VEC[i][15:8]);
            check("R8/R9 dec_err", {31'd0, dec_err}, {31'd0, VEC[i][32]});
            if (!VEC[i][33]) check("R3-R8 rdata", {24'd0, rdata}, {24'd0, VEC[i][7:0]});
        end

        sel_check(16'h0000, 3'b011);
        sel_check(16'h2FFF, 3'b011);
        sel_check(16'h3000, 3'b101);
        sel_check(16'h3FFF, 3'b101);
        sel_check(16'h4000, 3'b110);
        sel_check(16'h7FFF, 3'b110);
        sel_check(16'h8000, 3'b111);
        sel_check(16'hFFFF, 3'b111);

        // R3 hold and R9 clear after an unmapped read followed by an idle cycle
        access(1'b0, 1'b1, 16'h9000, 8'h00);
        check("R8 flag", {31'd0, dec_err}, 32'd1);
        @(negedge clk);
        addr = 16'h0000;
        @(negedge clk);
        check("R3 hold", {24'd0, rdata}, 32'hFF);
        check("R9 idle clear", {31'd0, dec_err}, 32'd0);

        // R10 reset clears I/O registers and leaves RAM alone
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 rdata cleared", {24'd0, rdata}, 32'd0);
        access(1'b0, 1'b1, 16'h3005, 8'h00);
        check("R10 io cleared", {24'd0, rdata}, 32'd0);
        access(1'b0, 1'b1, 16'h4000, 8'h00);
        check("R10 ram kept", {24'd0, rdata}, 32'h11);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule